// File: doc/BRIEF.md
# ADC Control and Conversion Sequencer

This block is the register-facing part of a multi-channel analog-to-digital converter. Software talks to it over a simple synchronous bus with 32-bit words. A control word selects the input channel, the reference, interrupt behaviour and the conversion clock divider. A data word holds the most recent result. A conversion starts when software raises the convert bit while the converter is enabled. A prescaled cycle counter then times the conversion.

When the counter expires, the block pulses a one-cycle sample strobe together with the channel index. In that same cycle it captures the code that the conversion front end presents on `samp_code`. It then clears the convert bit and, if interrupts are enabled, sets a sticky interrupt flag. The interrupt output is a level that follows that flag. Software clears the flag by writing a one to it. Writing the soft-reset bit returns everything to its reset state. The analog path and the arithmetic that produces a code are outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word sits at byte offset 0x0 and the data word at 0x4. The data word is read-only and its code is zero-extended. A write to 0x4, and any access to another offset, including an unaligned one, changes nothing. Any offset other than 0x0 and 0x4 reads as 0.
- R2: After reset, the control word reads 0x000C0001, the data word reads 0, and `irq_o` is high.
- R3: The interrupt flag is bit 18. Writing 1 there clears it. Writing 0 leaves it as it was. `irq_o` always equals this flag.
- R4: A control write with bit 16 set restores both words to their reset values and cancels any running conversion. No sample strobe follows it.
- R5: A conversion starts only on a control write that has enable (bit 17) set and takes convert (bit 13) from 0 to 1. Writing convert while it is already 1, or with enable clear, starts nothing.
- R6: A control write with enable set and convert clear aborts a running conversion. No strobe follows, and the data word keeps its value.
- R7: A conversion ends 20 x 2 x (DIV+1) clock cycles after the starting write. DIV is bits 8:1 of that write, a value from 0 to 255.
- R8: On completion, the data word takes `samp_code`, convert clears, and bits 18 and `irq_o` go high if interrupt enable (bit 21) is set. They are left unchanged if it is clear.
- R9: The channel field is bits 27:24. Eight channels exist. If the field holds 8 to 15 when the counter expires, the completion is dropped: there is no strobe, no data update and no interrupt, and convert stays 1.
- R10: `samp_stb` is high for exactly one cycle per accepted completion, with `samp_chan` giving the channel. `ref_sel_o` follows control bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| samp_stb | output | 1 | One-cycle completion strobe |
| samp_chan | output | 4 | Channel index of the completing conversion |
| samp_code | input | 10 | Conversion code, sampled while `samp_stb` is high |
| ref_sel_o | output | 1 | Reference select level |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus does not write the control word in the same cycle as a timer expiry. The reason is that such a write overrides the completion, so the strobe and interrupt relations would then describe the write, not the conversion. They also assume that `samp_code` is stable while the strobe is high. The bench drives the bus only while no conversion is near its end: it waits whole conversion lengths or stops early. Its front-end model derives the code combinationally from `samp_chan`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int OFS_CTRL = 0;
   localparam int OFS_DATA = 4;

   localparam int BIT_CHAN_LO = 24;
   localparam int BIT_IEN     = 21;
   localparam int BIT_REFSEL  = 19;
   localparam int BIT_FLAG    = 18;
   localparam int BIT_ENABLE  = 17;
   localparam int BIT_SRST    = 16;
   localparam int BIT_CONV    = 13;
   localparam int BIT_DIV_LO  = 1;
   localparam int DIV_W       = 8;
   localparam int CHAN_W      = 4;

   localparam logic [31:0] CTRL_RESET = 32'h000C_0001;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CTRL = 2'd1,
      HIT_DATA = 2'd2
   } reg_hit_e;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CODE_W = 10
) (
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       ctrl_q,
   input  logic [CODE_W-1:0] data_q,
   output logic              ctrl_wr,
   output logic [31:0]       bus_rdata
);
   reg_hit_e hit;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))      hit = HIT_CTRL;
      else if (bus_addr == ADDR_W'(OFS_DATA)) hit = HIT_DATA;
      else                                    hit = HIT_NONE;
   end

   assign ctrl_wr = bus_en && bus_we && (hit == HIT_CTRL);

   generate
      if (CODE_W == 32) begin : g_full
         always_comb begin
            bus_rdata = '0;
            if (bus_en && !bus_we) begin
               if (hit == HIT_CTRL)      bus_rdata = ctrl_q;
               else if (hit == HIT_DATA) bus_rdata = data_q;
            end
         end
      end else begin : g_ext
         always_comb begin
            bus_rdata = '0;
            if (bus_en && !bus_we) begin
               if (hit == HIT_CTRL)      bus_rdata = ctrl_q;
               else if (hit == HIT_DATA) bus_rdata = {{(32-CODE_W){1'b0}}, data_q};
            end
         end
      end
   endgenerate
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
   import adc_seq_pkg::*;
#(
   parameter int CONV_CYCLES = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             expire_o
);
   localparam int MAX_TICKS = CONV_CYCLES * 2 * (2 ** DIV_W);
   localparam int CNT_W     = $clog2(MAX_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [CNT_W-1:0] load_v;

   assign load_v = CNT_W'(CONV_CYCLES * 2) * (CNT_W'(div_i) + CNT_W'(1)) - CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (stop_i) begin
         busy_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= load_v;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_seq_pkg::*;
#(
   parameter int NUM_CHAN = 8,
   parameter int CODE_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [31:0]       wdata,
   input  logic              expire_i,
   input  logic [CODE_W-1:0] samp_code,
   output logic [31:0]       ctrl_q,
   output logic [CODE_W-1:0] data_q,
   output logic              start_o,
   output logic              stop_o,
   output logic              done_o,
   output logic [CHAN_W-1:0] chan_o
);
   logic [31:0] ctrl_mid;
   logic [31:0] ctrl_nxt;
   logic        soft_rst;
   logic        abort;
   logic        chan_ok;

   always_comb begin
      ctrl_mid = ctrl_q;
      if (ctrl_wr) begin
         ctrl_mid           = wdata;
         ctrl_mid[BIT_FLAG] = wdata[BIT_FLAG] ? 1'b0 : ctrl_q[BIT_FLAG];
      end
   end

   assign chan_o   = ctrl_mid[BIT_CHAN_LO +: CHAN_W];
   assign soft_rst = ctrl_wr && wdata[BIT_SRST];
   assign start_o  = ctrl_wr && !soft_rst && wdata[BIT_ENABLE] && wdata[BIT_CONV]
                     && !ctrl_q[BIT_CONV];
   assign abort    = ctrl_wr && !soft_rst && wdata[BIT_ENABLE] && !wdata[BIT_CONV];
   assign stop_o   = soft_rst || abort;

   generate
      if (NUM_CHAN == (2 ** CHAN_W)) begin : g_all_valid
         assign chan_ok = 1'b1;
      end else begin : g_range
         assign chan_ok = chan_o < CHAN_W'(NUM_CHAN);
      end
   endgenerate

   assign done_o = expire_i && chan_ok && !stop_o && !start_o;

   always_comb begin
      ctrl_nxt = ctrl_mid;
      if (done_o) begin
         ctrl_nxt[BIT_CONV] = 1'b0;
         if (ctrl_mid[BIT_IEN]) ctrl_nxt[BIT_FLAG] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         ctrl_q <= CTRL_RESET;
         data_q <= '0;
      end else begin
         ctrl_q <= ctrl_nxt;
         if (done_o) data_q <= samp_code;
      end
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int NUM_CHAN    = 8,
   parameter int CODE_W      = 10,
   parameter int CONV_CYCLES = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              samp_stb,
   output logic [CHAN_W-1:0] samp_chan,
   input  logic [CODE_W-1:0] samp_code,
   output logic              ref_sel_o,
   output logic              irq_o
);
   generate
      if (ADDR_W < 3)
         $error("adc_seq_ctrl: ADDR_W must reach offset 0x4");
      if (NUM_CHAN < 1 || NUM_CHAN > 2 ** CHAN_W)
         $error("adc_seq_ctrl: NUM_CHAN out of range of the channel field");
      if (CODE_W < 1 || CODE_W > 32)
         $error("adc_seq_ctrl: CODE_W must be 1..32");
      if (CONV_CYCLES < 1)
         $error("adc_seq_ctrl: CONV_CYCLES must be positive");
   endgenerate

   logic              ctrl_wr;
   logic [31:0]       ctrl_q;
   logic [CODE_W-1:0] data_q;
   logic              start;
   logic              stop;
   logic              expire;
   logic              done;
   logic [CHAN_W-1:0] chan;

   adc_bus_decode #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_decode (
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .ctrl_q    (ctrl_q),
      .data_q    (data_q),
      .ctrl_wr   (ctrl_wr),
      .bus_rdata (bus_rdata)
   );

   adc_ctrl_reg #(.NUM_CHAN(NUM_CHAN), .CODE_W(CODE_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .wdata     (bus_wdata),
      .expire_i  (expire),
      .samp_code (samp_code),
      .ctrl_q    (ctrl_q),
      .data_q    (data_q),
      .start_o   (start),
      .stop_o    (stop),
      .done_o    (done),
      .chan_o    (chan)
   );

   adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .stop_i   (stop),
      .div_i    (bus_wdata[BIT_DIV_LO +: DIV_W]),
      .expire_o (expire)
   );

   assign samp_stb  = done;
   assign samp_chan = chan;
   assign ref_sel_o = ctrl_q[BIT_REFSEL];
   assign irq_o     = ctrl_q[BIT_FLAG];
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_CHAN = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              samp_stb,
   input logic [CHAN_W-1:0] samp_chan,
   input logic              ref_sel_o,
   input logic              irq_o
);
   logic ctrl_write;
   assign ctrl_write = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_write && bus_wdata[BIT_FLAG] && !bus_wdata[BIT_SRST] && !samp_stb) |=> !irq_o);

   assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_write && bus_wdata[BIT_SRST]) |=> (irq_o && ref_sel_o && !samp_stb));

   assert_stb_valid_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
      samp_stb |-> (samp_chan < CHAN_W'(NUM_CHAN)));

   assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      samp_stb |=> !samp_stb);

   assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(samp_stb) || $past(ctrl_write && bus_wdata[BIT_SRST])));
endmodule

bind adc_seq_ctrl adc_seq_checker #(.ADDR_W(ADDR_W), .NUM_CHAN(NUM_CHAN)) i_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .samp_stb  (samp_stb),
   .samp_chan (samp_chan),
   .ref_sel_o (ref_sel_o),
   .irq_o     (irq_o)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   localparam logic [31:0] F_EN   = 32'h1 << 17;
   localparam logic [31:0] F_CONV = 32'h1 << 13;
   localparam logic [31:0] F_IEN  = 32'h1 << 21;
   localparam logic [31:0] F_REF  = 32'h1 << 19;
   localparam logic [31:0] F_FLAG = 32'h1 << 18;
   localparam logic [31:0] F_SRST = 32'h1 << 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        samp_stb;
   logic [3:0]  samp_chan;
   logic [9:0]  samp_code;
   logic        ref_sel_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   int ncyc = 0;
   int exp_chan[$];
   int exp_due[$];

   always #10 clk = ~clk;

   function automatic logic [9:0] code_of(input logic [3:0] ch);
      return 10'(ch) * 10'd64 + 10'd5;
   endfunction

   assign samp_code = code_of(samp_chan);

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .samp_stb(samp_stb), .samp_chan(samp_chan), .samp_code(samp_code),
      .ref_sel_o(ref_sel_o), .irq_o(irq_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // monitor: pops expected completions as the strobe appears
   always @(negedge clk) begin
      ncyc++;
      if (rst_n && samp_stb) begin
         if (exp_chan.size() == 0) begin
            chk(1'b0, "R6/R9 unexpected strobe", 32'(samp_chan), 32'hFFFF_FFFF);
         end else begin
            int ch;
            int due;
            ch  = exp_chan.pop_front();
            due = exp_due.pop_front();
            chk(samp_chan == 4'(ch), "R10 strobe channel", 32'(samp_chan), 32'(ch));
            chk(ncyc == due, "R7 completion cycle", 32'(ncyc), 32'(due));
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d, output int t);
      @(negedge clk); #1;
      t = ncyc;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); #1;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   // driver: start a conversion and push the expected completion
   task automatic start_conv(input int ch, input int dv, input logic [31:0] extra);
      int t;
      wr(12'h0, (32'(ch) << 24) | F_EN | F_CONV | (32'(dv) << 1) | extra, t);
      exp_chan.push_back(ch);
      exp_due.push_back(t + 20 * 2 * (dv + 1));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 32'(ncyc), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int t;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2 reset state
      rd(12'h0, v); chk(v == 32'h000C0001, "R2 ctrl reset", v, 32'h000C0001);
      rd(12'h4, v); chk(v == 32'h0, "R2 data reset", v, 32'h0);
      chk(irq_o == 1'b1, "R2 irq after reset", 32'(irq_o), 32'd1);

      // R3 clear the flag by writing one
      wr(12'h0, F_FLAG, t);
      chk(irq_o == 1'b0, "R3 w1c irq", 32'(irq_o), 32'd0);
      rd(12'h0, v); chk(v == 32'h0, "R3 w1c ctrl", v, 32'h0);

      // R7 R8 channel 3, DIV 0, interrupt enabled
      start_conv(3, 0, F_IEN);
      chk(ref_sel_o == 1'b0, "R10 ref_sel low", 32'(ref_sel_o), 32'd0);
      idle(45);
      chk(exp_chan.size() == 0, "R8 completion seen", 32'(exp_chan.size()), 32'd0);
      rd(12'h4, v); chk(v == 32'(code_of(4'd3)), "R8 data ch3", v, 32'(code_of(4'd3)));
      rd(12'h0, v);
      chk(v == ((32'd3 << 24) | F_IEN | F_EN | F_FLAG), "R8 ctrl after done", v,
          (32'd3 << 24) | F_IEN | F_EN | F_FLAG);
      chk(irq_o == 1'b1, "R8 irq raised", 32'(irq_o), 32'd1);

      // R3 writing zero to the flag keeps it
      wr(12'h0, 32'h0, t);
      chk(irq_o == 1'b1, "R3 write0 keeps irq", 32'(irq_o), 32'd1);
      rd(12'h0, v); chk(v == F_FLAG, "R3 write0 ctrl", v, F_FLAG);
      wr(12'h0, F_FLAG, t);
      chk(irq_o == 1'b0, "R3 cleared again", 32'(irq_o), 32'd0);

      // R7 R8 channel 7, DIV 2, no interrupt, reference bit set
      start_conv(7, 2, F_REF);
      chk(ref_sel_o == 1'b1, "R10 ref_sel high", 32'(ref_sel_o), 32'd1);
      idle(125);
      chk(exp_chan.size() == 0, "R7 div2 completion seen", 32'(exp_chan.size()), 32'd0);
      rd(12'h4, v); chk(v == 32'(code_of(4'd7)), "R8 data ch7", v, 32'(code_of(4'd7)));
      chk(irq_o == 1'b0, "R8 no irq without enable", 32'(irq_o), 32'd0);

      // R6 abort
      wr(12'h0, (32'd1 << 24) | F_EN | F_CONV, t);
      idle(10);
      wr(12'h0, (32'd1 << 24) | F_EN, t);
      idle(60);
      rd(12'h4, v); chk(v == 32'(code_of(4'd7)), "R6 data kept", v, 32'(code_of(4'd7)));
      rd(12'h0, v); chk(v == ((32'd1 << 24) | F_EN), "R6 ctrl", v, (32'd1 << 24) | F_EN);

      // R9 invalid channel
      wr(12'h0, (32'd9 << 24) | F_EN | F_CONV | F_IEN, t);
      idle(60);
      rd(12'h0, v);
      chk(v == ((32'd9 << 24) | F_EN | F_CONV | F_IEN), "R9 convert stays", v,
          (32'd9 << 24) | F_EN | F_CONV | F_IEN);
      rd(12'h4, v); chk(v == 32'(code_of(4'd7)), "R9 data kept", v, 32'(code_of(4'd7)));
      chk(irq_o == 1'b0, "R9 no irq", 32'(irq_o), 32'd0);

      // R5 convert already set: no restart
      wr(12'h0, (32'd2 << 24) | F_EN | F_CONV, t);
      idle(60);
      rd(12'h4, v); chk(v == 32'(code_of(4'd7)), "R5 no retrigger", v, 32'(code_of(4'd7)));
      wr(12'h0, (32'd2 << 24) | F_EN, t);
      start_conv(2, 0, 32'h0);
      idle(45);
      rd(12'h4, v); chk(v == 32'(code_of(4'd2)), "R5 rising edge starts", v, 32'(code_of(4'd2)));

      // R5 enable clear: no start
      wr(12'h0, (32'd4 << 24) | F_CONV, t);
      idle(60);
      rd(12'h4, v); chk(v == 32'(code_of(4'd2)), "R5 enable off", v, 32'(code_of(4'd2)));
      wr(12'h0, 32'h0, t);

      // R7 largest divider, channel 0
      start_conv(0, 255, 32'h0);
      idle(10245);
      chk(exp_chan.size() == 0, "R7 div255 completion seen", 32'(exp_chan.size()), 32'd0);
      rd(12'h4, v); chk(v == 32'(code_of(4'd0)), "R8 data ch0", v, 32'(code_of(4'd0)));

      // R4 soft reset during a conversion
      wr(12'h0, (32'd5 << 24) | F_EN | F_CONV, t);
      idle(5);
      wr(12'h0, F_SRST, t);
      rd(12'h0, v); chk(v == 32'h000C0001, "R4 ctrl reset", v, 32'h000C0001);
      rd(12'h4, v); chk(v == 32'h0, "R4 data reset", v, 32'h0);
      chk(irq_o == 1'b1, "R4 irq", 32'(irq_o), 32'd1);
      idle(60);

      // R1 ignored accesses
      wr(12'h4, 32'h3FF, t);
      rd(12'h4, v); chk(v == 32'h0, "R1 data read-only", v, 32'h0);
      wr(12'h8, 32'hFFFF_FFFF, t);
      wr(12'h1, 32'h0000_0000, t);
      rd(12'h8, v); chk(v == 32'h0, "R1 undefined reads 0", v, 32'h0);
      rd(12'h1, v); chk(v == 32'h0, "R1 unaligned reads 0", v, 32'h0);
      rd(12'h0, v); chk(v == 32'h000C0001, "R1 ctrl untouched", v, 32'h000C0001);
      chk(exp_chan.size() == 0, "R6 queue drained", 32'(exp_chan.size()), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule